// File: doc/BRIEF.md
# Script Branch and Parameter-Table Address Unit

This unit computes effective addresses for the script I/O instructions that choose a connection target. When an instruction is accepted, the unit produces a branch target. In relative mode the target is the current instruction pointer plus a signed displacement. Otherwise the target is the absolute address word taken from the instruction.

In parallel, an instruction may request an indirect lookup. In that case a signed offset from the count word is added to a per-I/O base register. The result is the address of a one-word parameter entry. The unit reads that word over a request/valid memory port. It then splits the word into four byte-wide connection parameters, holds them, and signals that they are ready.

Instruction decode supplies the mode flags and a flag that marks the select-family opcodes: select, reselect, wait-for-select and wait-for-reselect. The memory and the bus-phase logic lie outside this unit.

Top module: `scriptAddrGen`

## Requirements
- R1: After reset, memReq, jumpValid, paramReady and alignErr are 0, and the four parameter outputs are 0.
- R2: A start is accepted when no table read is outstanding. When relMode=1 and selFamily=1, jumpTarget becomes instrPtr plus jumpWord[23:0] sign-extended to 32 bits (the sum wraps modulo 2^32). In the same cycle jumpValid is high for one cycle, one clock after the accepting edge.
- R3: When selFamily=0, relMode is ignored and jumpTarget becomes jumpWord unchanged.
- R4: When relMode=0, jumpTarget becomes jumpWord unchanged.
- R5: An accepted start with tblMode=1 raises memReq one clock later. memAddr equals dsBase plus countWord sign-extended to 32 bits, with bits [1:0] forced to 0. memReq and memAddr then hold until memValid is sampled high.
- R6: Negative offsets reach down to -0x800000 and positive offsets reach up to 0x7FFFFC. The sum wraps modulo 2^32.
- R7: alignErr is updated at every accepted table start. It is set to 1 when countWord[1:0] is not 00 and cleared otherwise. Starts without a table lookup leave it unchanged.
- R8: When memValid is sampled while memReq=1, the unit latches four fields from memData: xferCtl from bits [31:24], targetId from [23:16], syncOffset from [15:8] and syncPeriod from [7:0]. The fields change at no other time.
- R9: One clock after memValid is sampled with memReq=1, paramReady is high for exactly one cycle and memReq is low.
- R10: A start presented while memReq=1 is ignored. jumpValid stays 0, and jumpTarget and memAddr are unchanged.
- R11: An accepted start with tblMode=0 does not raise memReq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Instruction presented for address generation |
| selFamily | input | 1 | Opcode is select, reselect, wait-select or wait-reselect |
| relMode | input | 1 | Relative-addressing mode flag from the opcode |
| tblMode | input | 1 | Table-indirect mode flag from the opcode |
| jumpWord | input | 32 | Jump-address word; low 24 bits are the displacement |
| countWord | input | 24 | Signed table offset from the count field |
| instrPtr | input | 32 | Current instruction pointer |
| dsBase | input | 32 | Data-structure base address |
| jumpTarget | output | 32 | Computed branch target |
| jumpValid | output | 1 | One-cycle strobe: jumpTarget updated |
| memReq | output | 1 | Parameter-word read request |
| memAddr | output | 32 | Parameter-word address, word aligned |
| memValid | input | 1 | Read data valid |
| memData | input | 32 | Read data |
| xferCtl | output | 8 | Latched transfer-control byte |
| targetId | output | 8 | Latched SCSI ID byte |
| syncOffset | output | 8 | Latched synchronous offset |
| syncPeriod | output | 8 | Latched synchronous period |
| paramReady | output | 1 | One-cycle strobe: parameters latched |
| alignErr | output | 1 | Last table offset had nonzero low bits |

## Verification
The bench builds the unit with its default widths: a 32-bit address, a 24-bit displacement and 8-bit fields. With these widths the ±8 MB reach limits are exact boundary values the bench can hit. These are an offset of 0x800000 below a base near zero, which wraps through 2^32, and an offset of 0x7FFFFC. With 8-bit fields, a word with four distinct bytes shows any swap in field position. Holding a memory response back for several cycles opens a window in which the bench presents a competing start and confirms that it is dropped.

// File: rtl/scriptAddrPkg.sv
package scriptAddrPkg;

  // Control-to-datapath strobes
  typedef struct packed {
    logic loadJump;     // capture branch target
    logic loadTbl;      // capture table address and alignment flag
    logic latchParams;  // capture parameter word fields
  } ctlStrobes_t;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } addrState_t;

endpackage

// File: rtl/scriptAddrCtrl.sv
module scriptAddrCtrl
  import scriptAddrPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  logic        tblMode,
  input  logic        memValid,
  output ctlStrobes_t strobes,
  output logic        memReq,
  output logic        jumpValid,
  output logic        paramReady
);

  addrState_t state, stateNext;
  logic accept;

  // A start is taken only when no table read is pending
  assign accept = startReq && (state == ST_IDLE);

  always_comb begin
    strobes.loadJump    = accept;
    strobes.loadTbl     = accept && tblMode;
    strobes.latchParams = (state == ST_WAIT) && memValid;
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (accept && tblMode) stateNext = ST_WAIT;
      ST_WAIT: if (memValid)          stateNext = ST_IDLE;
      default:                        stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      jumpValid  <= 1'b0;
      paramReady <= 1'b0;
    end else begin
      state      <= stateNext;
      jumpValid  <= accept;
      paramReady <= strobes.latchParams;
    end
  end

  assign memReq = (state == ST_WAIT);

endmodule

// File: rtl/scriptAddrDatapath.sv
module scriptAddrDatapath
  import scriptAddrPkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DISP_W     = 24,
  parameter int FIELD_W    = 8,
  parameter int NUM_FIELDS = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  ctlStrobes_t                 strobes,
  input  logic                        selFamily,
  input  logic                        relMode,
  input  logic [ADDR_W-1:0]           jumpWord,
  input  logic [DISP_W-1:0]           countWord,
  input  logic [ADDR_W-1:0]           instrPtr,
  input  logic [ADDR_W-1:0]           dsBase,
  input  logic [NUM_FIELDS*FIELD_W-1:0] memData,
  output logic [ADDR_W-1:0]           jumpTarget,
  output logic [ADDR_W-1:0]           memAddr,
  output logic                        alignErr,
  output logic [NUM_FIELDS-1:0][FIELD_W-1:0] fields
);

  localparam int EXT_W   = ADDR_W - DISP_W;
  localparam int ALIGN_W = 2;

  logic [ADDR_W-1:0] dispExt, offExt, relSum, tblSum, jumpNext;

  assign dispExt  = {{EXT_W{jumpWord[DISP_W-1]}}, jumpWord[DISP_W-1:0]};
  assign offExt   = {{EXT_W{countWord[DISP_W-1]}}, countWord};
  assign relSum   = instrPtr + dispExt;
  assign tblSum   = dsBase + offExt;
  // Relative mode applies only to the select-family opcodes
  assign jumpNext = (relMode && selFamily) ? relSum : jumpWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      jumpTarget <= '0;
      memAddr    <= '0;
      alignErr   <= 1'b0;
    end else begin
      if (strobes.loadJump) jumpTarget <= jumpNext;
      if (strobes.loadTbl) begin
        memAddr  <= {tblSum[ADDR_W-1:ALIGN_W], {ALIGN_W{1'b0}}};
        alignErr <= |countWord[ALIGN_W-1:0];
      end
    end
  end

  // Field 0 comes from the most significant byte lane
  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                   fields[i] <= '0;
      else if (strobes.latchParams) fields[i] <= memData[(NUM_FIELDS-1-i)*FIELD_W +: FIELD_W];
    end
  end

endmodule

// File: rtl/scriptAddrGen.sv
module scriptAddrGen
  import scriptAddrPkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DISP_W  = 24,
  parameter int FIELD_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 startReq,
  input  logic                 selFamily,
  input  logic                 relMode,
  input  logic                 tblMode,
  input  logic [ADDR_W-1:0]    jumpWord,
  input  logic [DISP_W-1:0]    countWord,
  input  logic [ADDR_W-1:0]    instrPtr,
  input  logic [ADDR_W-1:0]    dsBase,
  output logic [ADDR_W-1:0]    jumpTarget,
  output logic                 jumpValid,
  output logic                 memReq,
  output logic [ADDR_W-1:0]    memAddr,
  input  logic                 memValid,
  input  logic [4*FIELD_W-1:0] memData,
  output logic [FIELD_W-1:0]   xferCtl,
  output logic [FIELD_W-1:0]   targetId,
  output logic [FIELD_W-1:0]   syncOffset,
  output logic [FIELD_W-1:0]   syncPeriod,
  output logic                 paramReady,
  output logic                 alignErr
);

  localparam int NUM_FIELDS = 4;

  ctlStrobes_t strobes;
  logic [NUM_FIELDS-1:0][FIELD_W-1:0] fields;

  scriptAddrCtrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .startReq   (startReq),
    .tblMode    (tblMode),
    .memValid   (memValid),
    .strobes    (strobes),
    .memReq     (memReq),
    .jumpValid  (jumpValid),
    .paramReady (paramReady)
  );

  scriptAddrDatapath #(
    .ADDR_W     (ADDR_W),
    .DISP_W     (DISP_W),
    .FIELD_W    (FIELD_W),
    .NUM_FIELDS (NUM_FIELDS)
  ) uData (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .selFamily  (selFamily),
    .relMode    (relMode),
    .jumpWord   (jumpWord),
    .countWord  (countWord),
    .instrPtr   (instrPtr),
    .dsBase     (dsBase),
    .memData    (memData),
    .jumpTarget (jumpTarget),
    .memAddr    (memAddr),
    .alignErr   (alignErr),
    .fields     (fields)
  );

  assign xferCtl    = fields[0];
  assign targetId   = fields[1];
  assign syncOffset = fields[2];
  assign syncPeriod = fields[3];

endmodule

// File: rtl/scriptAddrChecker.sv
module scriptAddrChecker #(
  parameter int ADDR_W  = 32,
  parameter int FIELD_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              startReq,
  input logic              memReq,
  input logic              memValid,
  input logic [ADDR_W-1:0] memAddr,
  input logic [ADDR_W-1:0] jumpTarget,
  input logic              jumpValid,
  input logic              paramReady,
  input logic [FIELD_W-1:0] syncPeriod,
  input logic [FIELD_W-1:0] xferCtl
);

  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memValid |=> memReq && $stable(memAddr));

  p_addr_aligned_r5: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> memAddr[1:0] == 2'b00);

  p_ready_after_valid_r9: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memValid |=> paramReady && !memReq);

  p_ready_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    paramReady |=> !paramReady);

  p_busy_start_dropped_r10: assert property (@(posedge clk) disable iff (!rstN)
    memReq && startReq |=> !jumpValid && $stable(jumpTarget));

  p_params_held_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(memReq && memValid) |=> $stable(syncPeriod) && $stable(xferCtl));

endmodule

bind scriptAddrGen scriptAddrChecker #(.ADDR_W(ADDR_W), .FIELD_W(FIELD_W)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .startReq   (startReq),
  .memReq     (memReq),
  .memValid   (memValid),
  .memAddr    (memAddr),
  .jumpTarget (jumpTarget),
  .jumpValid  (jumpValid),
  .paramReady (paramReady),
  .syncPeriod (syncPeriod),
  .xferCtl    (xferCtl)
);

// File: tb/scriptAddrGen_test.sv
`timescale 1ns/1ps
module scriptAddrGen_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0, selFamily = 1'b0, relMode = 1'b0, tblMode = 1'b0;
  logic [31:0] jumpWord = '0, instrPtr = '0, dsBase = '0, memData = '0;
  logic [23:0] countWord = '0;
  logic        memValid = 1'b0;
  logic [31:0] jumpTarget, memAddr;
  logic        jumpValid, memReq, paramReady, alignErr;
  logic [7:0]  xferCtl, targetId, syncOffset, syncPeriod;

  int testCnt = 0;
  int failCnt = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  scriptAddrGen uut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .selFamily(selFamily),
    .relMode(relMode), .tblMode(tblMode), .jumpWord(jumpWord),
    .countWord(countWord), .instrPtr(instrPtr), .dsBase(dsBase),
    .jumpTarget(jumpTarget), .jumpValid(jumpValid), .memReq(memReq),
    .memAddr(memAddr), .memValid(memValid), .memData(memData),
    .xferCtl(xferCtl), .targetId(targetId), .syncOffset(syncOffset),
    .syncPeriod(syncPeriod), .paramReady(paramReady), .alignErr(alignErr)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Present one instruction for a single cycle; returns at the following negedge
  task automatic issue(logic sel, logic rel, logic tbl, logic [31:0] jw,
                       logic [23:0] cw, logic [31:0] ip, logic [31:0] base);
    @(negedge clk);
    selFamily = sel; relMode = rel; tblMode = tbl;
    jumpWord = jw; countWord = cw; instrPtr = ip; dsBase = base;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
  endtask

  // Supply a memory word for one cycle; returns at the following negedge
  task automatic respond(logic [31:0] data);
    memData = data; memValid = 1'b1;
    @(negedge clk);
    memValid = 1'b0; memData = '0;
  endtask

  task automatic testReset();
    chk("R1", "memReq", {31'd0, memReq}, 32'd0);
    chk("R1", "jumpValid", {31'd0, jumpValid}, 32'd0);
    chk("R1", "paramReady", {31'd0, paramReady}, 32'd0);
    chk("R1", "alignErr", {31'd0, alignErr}, 32'd0);
    chk("R1", "params", {xferCtl, targetId, syncOffset, syncPeriod}, 32'd0);
  endtask

  task automatic testRelative();
    issue(1, 1, 0, 32'hAB000010, 24'd0, 32'h00001000, 32'd0);
    chk("R2", "jumpValid", {31'd0, jumpValid}, 32'd1);
    chk("R2", "positive disp", jumpTarget, 32'h00001010);
    chk("R11", "no memReq", {31'd0, memReq}, 32'd0);
    @(negedge clk);
    chk("R2", "jumpValid pulse", {31'd0, jumpValid}, 32'd0);
    issue(1, 1, 0, 32'h00FFFFF0, 24'd0, 32'h00001000, 32'd0);
    chk("R2", "negative disp", jumpTarget, 32'h00000FF0);
  endtask

  task automatic testAbsolute();
    issue(0, 1, 0, 32'h12345678, 24'd0, 32'h00001000, 32'd0);
    chk("R3", "rel ignored non-select", jumpTarget, 32'h12345678);
    issue(1, 0, 0, 32'h9ABCDEF0, 24'd0, 32'h00001000, 32'd0);
    chk("R4", "rel clear", jumpTarget, 32'h9ABCDEF0);
  endtask

  task automatic testTableAndBusy();
    issue(1, 0, 1, 32'h00000400, 24'h000100, 32'd0, 32'h10000000);
    chk("R5", "memReq", {31'd0, memReq}, 32'd1);
    chk("R5", "memAddr", memAddr, 32'h10000100);
    chk("R7", "aligned", {31'd0, alignErr}, 32'd0);
    // Competing start while the read is pending
    issue(1, 1, 1, 32'h00000020, 24'h000200, 32'h00005000, 32'h20000000);
    chk("R10", "jumpValid", {31'd0, jumpValid}, 32'd0);
    chk("R10", "jumpTarget", jumpTarget, 32'h00000400);
    chk("R10", "memAddr", memAddr, 32'h10000100);
    chk("R5", "memReq held", {31'd0, memReq}, 32'd1);
    respond(32'h11223344);
    chk("R9", "paramReady", {31'd0, paramReady}, 32'd1);
    chk("R9", "memReq low", {31'd0, memReq}, 32'd0);
    chk("R8", "xferCtl", {24'd0, xferCtl}, 32'h11);
    chk("R8", "targetId", {24'd0, targetId}, 32'h22);
    chk("R8", "syncOffset", {24'd0, syncOffset}, 32'h33);
    chk("R8", "syncPeriod", {24'd0, syncPeriod}, 32'h44);
    @(negedge clk);
    chk("R9", "paramReady pulse", {31'd0, paramReady}, 32'd0);
    memData = 32'hDEADBEEF;
    @(negedge clk);
    chk("R8", "fields held", {xferCtl, targetId, syncOffset, syncPeriod}, 32'h11223344);
    memData = '0;
  endtask

  task automatic testReach();
    issue(0, 0, 1, 32'd0, 24'h800000, 32'd0, 32'h00400000);
    chk("R6", "min offset wrap", memAddr, 32'hFFC00000);
    respond(32'hA1B2C3D4);
    chk("R8", "second word", {xferCtl, targetId, syncOffset, syncPeriod}, 32'hA1B2C3D4);
    issue(0, 0, 1, 32'd0, 24'h7FFFFC, 32'd0, 32'h00000000);
    chk("R6", "max offset", memAddr, 32'h007FFFFC);
    respond(32'h0);
  endtask

  task automatic testMisaligned();
    issue(0, 0, 1, 32'd0, 24'h000103, 32'd0, 32'h10000000);
    chk("R7", "alignErr set", {31'd0, alignErr}, 32'd1);
    chk("R5", "low bits forced", memAddr, 32'h10000100);
    respond(32'h0);
    issue(0, 0, 0, 32'h00000050, 24'h000001, 32'd0, 32'd0);
    chk("R7", "kept on non-table", {31'd0, alignErr}, 32'd1);
    chk("R11", "no memReq", {31'd0, memReq}, 32'd0);
    issue(0, 0, 1, 32'd0, 24'hFFFFFC, 32'd0, 32'h10000000);
    chk("R7", "alignErr cleared", {31'd0, alignErr}, 32'd0);
    chk("R6", "negative offset", memAddr, 32'h0FFFFFFC);
    respond(32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testRelative();
    testAbsolute();
    testTableAndBusy();
    testReach();
    testMisaligned();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      testCnt++;
      failCnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

endmodule